// File: doc/BRIEF.md
# Lockable CMOS RAM Controller

This block holds the general-purpose battery-backed bytes that sit next to a real-time clock: a 128-byte standard bank, whose first 14 bytes belong to the clock's time, date and control registers, and a 128-byte extended bank. The host reaches any byte through a bank select and a 7-bit index. A write completes in the accepting cycle. Read data appears one cycle later, together with a valid strobe.

Two 8-byte windows can be sealed. The lower window is standard-bank bytes 38h–3Fh and the upper window is extended-bank bytes 38h–3Fh. Each has its own lock bit. A lock bit is set by writing 1 to it. It stays set until the hard reset. A sealed window keeps its contents: writes to it are dropped, and reads return FFh. The stored bytes are not reset, so after a hard reset the window shows its old contents again.

A clear request wipes the user area to 00h, one byte per clock. It covers standard bytes 0Eh–7Fh and then the whole extended bank, and it leaves the clock bytes alone. While the wipe runs, the controller raises busy and stalls the host.

Top module: `cmos_lockram`

## Requirements
- R1: After reset, busy is 0 and rd_valid is 0. Both lock bits are 0.
- R2: A host access is accepted in a cycle where host_req=1 and busy=0. A write stores wr_data at {bank,index} in that cycle. A read drives rd_data and a one-cycle rd_valid pulse in the next cycle. Both banks are addressable at all 128 indices.
- R3: A read accepted inside a locked window returns FFh. The stored byte is kept.
- R4: A write accepted inside a locked window leaves the stored byte unchanged.
- R5: lock_set bit 0 seals the lower window (bank 0, index 38h–3Fh). lock_set bit 1 seals the upper window (bank 1, index 38h–3Fh). A lock bit is set only when lock_we=1 and that bit of lock_set is 1. Writing 0 has no effect. Only rst_n low clears a lock bit.
- R6: A clear writes 00h to standard bytes 0Eh–7Fh and to all extended bytes, locked windows included.
- R7: A clear leaves standard bytes 00h–0Dh unchanged.
- R8: clr_req sampled while busy=0 raises busy from the next cycle for exactly 242 cycles (one per cleared byte). While busy=1, host requests and further clear requests are ignored.
- R9: Bytes outside the two windows are unaffected by the lock bits.
- R10: Stored bytes are not altered by rst_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| host_req | input | 1 | Access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_bank | input | 1 | 0 = standard bank, 1 = extended bank |
| host_index | input | 7 | Byte index in the bank |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, held until the next read |
| rd_valid | output | 1 | Read data strobe, one cycle |
| lock_we | input | 1 | Lock bit update strobe |
| lock_set | input | 2 | Bit 0 = lower window, bit 1 = upper window; 1 sets the bit |
| clr_req | input | 1 | Start a wipe of the user area |
| busy | output | 1 | Wipe in progress; host stalled |

## Verification
The assertions assume that the host does not raise clr_req in the same cycle as an accepted access. They also assume that the lock strobe is only meaningful while rst_n is high. The stimulus drives every input on the falling edge and raises only one kind of request per cycle. It attempts a host write only once busy is already high, so the wipe and an accepted access never meet.

// File: rtl/cmos_lockram_pkg.sv
package cmos_lockram_pkg;
  localparam int unsigned IDX_W      = 7;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned CLK_BYTES  = 14;
  localparam int unsigned WIN_BYTES  = 8;
  localparam int unsigned LO_BASE    = 'h38;
  localparam int unsigned HI_BASE    = 'h38;
  localparam int unsigned N_LOCKS    = 2;
  localparam logic [7:0]  SEALED_VAL = 8'hFF;

  typedef enum logic [0:0] {BANK_STD = 1'b0, BANK_EXT = 1'b1} bank_e;
endpackage

// File: rtl/cmos_lock_ctrl.sv
module cmos_lock_ctrl #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lock_we,
  input  logic [N-1:0] lock_set,
  output logic [N-1:0] lock_q
);
  logic [N-1:0] lock_d;

  always_comb begin
    lock_d = lock_q;
    if (lock_we) lock_d = lock_q | lock_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= '0;
    else        lock_q <= lock_d;
  end

  for (genvar g = 0; g < N; g++) begin : g_sticky
    // R5: once set, a lock bit holds until reset
    a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q[g] |=> lock_q[g]);
  end
endmodule

// File: rtl/cmos_clear_seq.sv
module cmos_clear_seq #(
  parameter int unsigned W     = 8,
  parameter int unsigned START = 14,
  parameter int unsigned LAST  = 255
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_req,
  output logic         busy,
  output logic [W-1:0] clr_idx
);
  localparam logic [W-1:0] START_V = W'(START);
  localparam logic [W-1:0] LAST_V  = W'(LAST);

  logic         busy_d;
  logic [W-1:0] idx_d;

  always_comb begin
    busy_d = busy;
    idx_d  = clr_idx;
    if (!busy && clr_req) begin
      busy_d = 1'b1;
      idx_d  = START_V;
    end else if (busy) begin
      if (clr_idx == LAST_V) busy_d = 1'b0;
      else                   idx_d  = clr_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      clr_idx <= '0;
    end else begin
      busy    <= busy_d;
      clr_idx <= idx_d;
    end
  end

  // R7: the wipe never points below the first user byte
  a_r7_spare_clock: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (clr_idx >= START_V));
  // R8: an idle request starts the wipe on the next cycle
  a_r8_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !busy) |=> (busy && clr_idx == START_V));
endmodule

// File: rtl/cmos_ram_array.sv
module cmos_ram_array #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/cmos_lockram.sv
module cmos_lockram
  import cmos_lockram_pkg::*;
#(
  parameter int unsigned IW   = IDX_W,
  parameter int unsigned DW   = BYTE_W,
  parameter int unsigned RSV  = CLK_BYTES,
  parameter int unsigned WLEN = WIN_BYTES,
  parameter int unsigned LOB  = LO_BASE,
  parameter int unsigned HIB  = HI_BASE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_we,
  input  logic          host_bank,
  input  logic [IW-1:0] host_index,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  input  logic          lock_we,
  input  logic [1:0]    lock_set,
  input  logic          clr_req,
  output logic          busy
);
  localparam int unsigned AW   = IW + 1;
  localparam int unsigned LAST = (1 << AW) - 1;

  logic [1:0]    lock_q;
  logic [AW-1:0] clr_idx, host_addr, mem_waddr;
  logic [DW-1:0] mem_wdata, mem_rd, rd_data_d;
  logic          acc, rd_acc, host_wr, mem_we, hit_lo, hit_hi, sealed;

  cmos_lock_ctrl #(.N(2)) u_lock (
    .clk(clk), .rst_n(rst_n), .lock_we(lock_we),
    .lock_set(lock_set), .lock_q(lock_q)
  );

  cmos_clear_seq #(.W(AW), .START(RSV), .LAST(LAST)) u_clr (
    .clk(clk), .rst_n(rst_n), .clr_req(clr_req),
    .busy(busy), .clr_idx(clr_idx)
  );

  cmos_ram_array #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(host_addr), .rdata(mem_rd)
  );

  always_comb begin
    host_addr = {host_bank, host_index};
    hit_lo    = (host_bank == BANK_STD) && (32'(host_index) >= LOB) && (32'(host_index) < LOB + WLEN);
    hit_hi    = (host_bank == BANK_EXT) && (32'(host_index) >= HIB) && (32'(host_index) < HIB + WLEN);
    sealed    = (hit_lo && lock_q[0]) || (hit_hi && lock_q[1]);
    acc       = host_req && !busy;
    rd_acc    = acc && !host_we;
    host_wr   = acc && host_we && !sealed;
    mem_we    = busy || host_wr;
    mem_waddr = busy ? clr_idx : host_addr;
    mem_wdata = busy ? '0 : wr_data;
    rd_data_d = rd_data;
    if (rd_acc) rd_data_d = sealed ? DW'(SEALED_VAL) : mem_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_data  <= rd_data_d;
      rd_valid <= rd_acc;
    end
  end

  // R3: a read of a sealed byte answers with the fixed pattern
  a_r3_sealed_read: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_we && !busy && sealed) |=> (rd_valid && rd_data == DW'(SEALED_VAL)));
  // R8: no read strobe follows a stalled cycle
  a_r8_host_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !rd_valid);
  // R2: an accepted read produces exactly one strobe
  a_r2_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_we && !busy) |=> rd_valid);
endmodule

// File: tb/tb_cmos_lockram.sv
module tb_cmos_lockram;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       host_req = 0, host_we = 0, host_bank = 0, lock_we = 0, clr_req = 0;
  logic [6:0] host_index = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic [1:0] lock_set = '0;
  logic       rd_valid, busy;
  int         n_cmp = 0, n_bad = 0;

  cmos_lockram dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_bank(host_bank), .host_index(host_index), .wr_data(wr_data),
    .rd_data(rd_data), .rd_valid(rd_valid), .lock_we(lock_we),
    .lock_set(lock_set), .clr_req(clr_req), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pat(input int b, input int a, input int k);
    return 8'((a * 7 + b * 90 + k * 37 + 3) & 8'hFF);
  endfunction

  function automatic bit in_lo(input int b, input int a);
    return b == 0 && a >= 'h38 && a < 'h40;
  endfunction

  function automatic bit in_hi(input int b, input int a);
    return b == 1 && a >= 'h38 && a < 'h40;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic wr(input int b, input int a, input logic [7:0] d);
    @(negedge clk);
    host_req = 1; host_we = 1; host_bank = b[0]; host_index = a[6:0]; wr_data = d;
    @(negedge clk);
    host_req = 0; host_we = 0;
  endtask

  task automatic rd(input int b, input int a, output logic [7:0] d, output logic v);
    @(negedge clk);
    host_req = 1; host_we = 0; host_bank = b[0]; host_index = a[6:0];
    @(negedge clk);
    host_req = 0;
    d = rd_data; v = rd_valid;
  endtask

  task automatic set_lock(input logic [1:0] s);
    @(negedge clk);
    lock_we = 1; lock_set = s;
    @(negedge clk);
    lock_we = 0; lock_set = '0;
  endtask

  task automatic write_all(input int k);
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 128; a++) wr(b, a, pat(b, a, k));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic       v;
    int         exp, cnt;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy", busy, 0);
    chk("R1 rd_valid", rd_valid, 0);
    rst_n = 1;
    @(negedge clk);

    // R2: every byte of both banks holds what was written
    write_all(0);
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 128; a++) begin
        rd(b, a, d, v);
        chk("R2 data", d, pat(b, a, 0));
        chk("R2 valid", v, 1);
      end
    // R1: locks are clear after reset, so the window reads its data
    rd(0, 'h3A, d, v);
    chk("R1 lock clear", d, pat(0, 'h3A, 0));

    // R5: writing zeros changes no lock
    set_lock(2'b00);
    rd(0, 'h38, d, v);
    chk("R5 zero write", d, pat(0, 'h38, 0));
    // R5: bit 0 seals only the lower window
    set_lock(2'b01);
    set_lock(2'b00);
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 128; a++) begin
        rd(b, a, d, v);
        exp = in_lo(b, a) ? 'hFF : pat(b, a, 0);
        chk(in_lo(b, a) ? "R3 sealed read" : "R9 open read", d, exp);
      end

    // R4: writes into the sealed window are dropped
    write_all(1);
    set_lock(2'b10);
    write_all(2);
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 128; a++) begin
        rd(b, a, d, v);
        exp = (in_lo(b, a) || in_hi(b, a)) ? 'hFF : pat(b, a, 2);
        chk("R9 both sealed", d, exp);
      end

    // R10/R5: hard reset releases locks, stored bytes survive
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    rst_n = 1;
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 128; a++) begin
        rd(b, a, d, v);
        exp = in_lo(b, a) ? pat(b, a, 0) : in_hi(b, a) ? pat(b, a, 1) : pat(b, a, 2);
        chk(in_lo(b, a) ? "R4 lower kept" : in_hi(b, a) ? "R4 upper kept" : "R10 kept", d, exp);
      end

    // R8: clear timing; stalled host write and repeat request ignored
    set_lock(2'b11);
    @(negedge clk); clr_req = 1;
    @(negedge clk); clr_req = 0;
    chk("R8 busy rise", busy, 1);
    cnt = 0;
    while (busy && cnt < 1000) begin
      if (cnt == 5) begin host_req = 1; host_we = 1; host_bank = 0; host_index = 7'h05; wr_data = 8'hC3; end
      if (cnt == 6) begin host_req = 0; host_we = 0; clr_req = 1; end
      if (cnt == 7) clr_req = 0;
      cnt++;
      @(negedge clk);
    end
    chk("R8 busy length", cnt, 242);
    chk("R8 no strobe", rd_valid, 0);
    @(negedge clk);
    chk("R8 no restart", busy, 0);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 128; a++) begin
        rd(b, a, d, v);
        if (b == 0 && a < 14) chk("R7 clock bytes", d, pat(b, a, 2));
        else                  chk("R6 wiped", d, 0);
      end
    finish_run();
  end
endmodule